// File: doc/BRIEF.md
# Serial flash page write engine

This block is the serial-slave side of a small flash store. A host on a mode-0 serial link (clock idles low, data sampled on the rising edge, most significant bit first) sends commands framed by an active-low select line. Two commands change the store. Page write replaces a run of bytes inside one page and leaves the rest of the page as it was. Page program can only clear bits. Both commands need a write-enable command first. Data bytes are gathered into a 256-byte page buffer while select is low. The internal cycle runs only after select is released cleanly.

The store is a handful of 256-byte pages held in registers. A page write cycle takes four steps: it fills the bytes that were not received from the old page, erases the page to all ones, waits out an erase time, and then programs the page after a program time. A page program cycle only ANDs the buffer into the page after the program time. A status command reports the busy flag and the enable latch, so the host can poll until a cycle ends. The rest of the chip reads the store through a plain combinational read port.

No byte stream leaves the block in parallel form, so there is no valid/ready pair and no back-pressure. The serial link sets its own pace, and every other pin is a plain level.

Top module: `spiflash_pgwr`

## Requirements
- R1: After reset the status byte reads 0x00 and every byte of the store reads 0xFF.
- R2: Opcode 0x05 returns the status byte on the serial output, most significant bit first, once after each later byte while select stays low. Bit 0 is busy (cycle in progress) and bit 1 is the write-enable latch. All other bits are 0.
- R3: Opcode 0x06 sets the write-enable latch. The latch stays set through an internal cycle and clears in the cycle in which busy falls.
- R4: A page write (0x0A) or page program (0x02) frame that arrives while the write-enable latch is clear changes nothing.
- R5: A frame is the opcode, then address bits 23..0 in three bytes, then data. The page is address bits [8 +: log2(NUM_PAGES)], and higher address bits are ignored. The first data byte lands at offset A7..A0.
- R6: Within one frame the offset wraps from 255 to 0 in the same page. A later byte at an offset replaces an earlier one.
- R7: A cycle starts only when select rises at a byte boundary after at least one data byte. Any other frame is discarded and leaves the latch as it was.
- R8: After a page write, each received offset holds exactly the received byte, and every other byte of the page keeps its old value.
- R9: After a page program, each received offset holds old AND new, and the other bytes are unchanged.
- R10: Busy is set from the cycle after select rises until the cycle ends. This lasts 1+ERASE_CYC+PROG_CYC clocks for page write and PROG_CYC clocks for page program.
- R11: While busy, every opcode except 0x05 is ignored, including 0x06.
- R12: rd_data shows the store byte at rd_addr (page in the upper bits, offset in the lower 8) with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out (status) |
| rd_addr | input | log2(NUM_PAGES)+8 | Store read address |
| rd_data | output | 8 | Store byte at rd_addr |

## Verification
The bench builds the block with NUM_PAGES=2, ERASE_CYC=600 and PROG_CYC=250. Two pages keep a full sweep of the store through the read port cheap after every command, so a stray write anywhere shows up. The long cycle times leave a whole status frame and two more command frames inside one cycle, which makes the busy flag and the ignored-while-busy rule observable from the serial pins. Full 256-byte pages, frames longer than a page, and offsets near 255 exercise the wrap, the overwrite and the merge against a byte model kept in the bench.

// File: rtl/spiflash_pkg.sv
package spiflash_pkg;
  localparam int PAGE_BYTES = 256;
  localparam int OFF_W      = 8;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PW   = 8'h0A;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_RDSR = 8'h05;

  typedef enum logic [1:0] {SQ_IDLE, SQ_MERGE, SQ_ERASE, SQ_PROG} seq_state_t;
endpackage

// File: rtl/sfp_spi_front.sv
module sfp_spi_front (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       sel,
  output logic       sel_fall,
  output logic       cs_rise,
  output logic       on_boundary,
  output logic [2:0] bit_cnt,
  output logic       byte_vld,
  output logic [7:0] byte_data
);
  logic [2:0] sck_s, cs_s, mo_s;
  logic [6:0] shreg;
  logic       sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      cs_s  <= '1;
      mo_s  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sclk};
      cs_s  <= {cs_s[1:0], cs_n};
      mo_s  <= {mo_s[1:0], mosi};
    end
  end

  assign sck_rise    = sck_s[1] & ~sck_s[2];
  assign sel         = ~cs_s[1];
  assign sel_fall    = ~cs_s[1] & cs_s[2];
  assign cs_rise     = cs_s[1] & ~cs_s[2];
  assign on_boundary = (bit_cnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[5:0], mo_s[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {shreg, mo_s[1]};
        end
      end
    end
  end
endmodule

// File: rtl/sfp_page_buf.sv
module sfp_page_buf
  import spiflash_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr,
  input  logic                             wr_en,
  input  logic [OFF_W-1:0]                 wr_off,
  input  logic [7:0]                       wr_data,
  input  logic                             merge,
  input  logic [PAGE_BYTES-1:0][7:0]       old_page,
  output logic [PAGE_BYTES-1:0][7:0]       data
);
  logic [PAGE_BYTES-1:0] got;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data[i] <= 8'hFF;
        got[i]  <= 1'b0;
      end else if (clr) begin
        data[i] <= 8'hFF;
        got[i]  <= 1'b0;
      end else if (wr_en && wr_off == OFF_W'(i)) begin
        data[i] <= wr_data;
        got[i]  <= 1'b1;
      end else if (merge && !got[i]) begin
        data[i] <= old_page[i];
      end
    end
  end
endmodule

// File: rtl/sfp_array.sv
module sfp_array
  import spiflash_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int PG_W = $clog2(NUM_PAGES),
  localparam int AW   = PG_W + OFF_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PG_W-1:0]            page_sel,
  input  logic                       erase,
  input  logic                       prog,
  input  logic [PAGE_BYTES-1:0][7:0] pbuf,
  output logic [PAGE_BYTES-1:0][7:0] cur_page,
  input  logic [AW-1:0]              raddr,
  output logic [7:0]                 rdata
);
  logic [NUM_PAGES-1:0][PAGE_BYTES-1:0][7:0] mem;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[p] <= '1;
      else if (erase && page_sel == PG_W'(p))
        mem[p] <= '1;
      else if (prog && page_sel == PG_W'(p))
        mem[p] <= mem[p] & pbuf;
    end
  end

  assign cur_page = mem[page_sel];
  assign rdata    = mem[raddr[AW-1:OFF_W]][raddr[OFF_W-1:0]];
endmodule

// File: rtl/sfp_wr_seq.sv
module sfp_wr_seq
  import spiflash_pkg::*;
#(
  parameter int ERASE_CYC = 64,
  parameter int PROG_CYC  = 32,
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CW   = $clog2(MAXC) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_pw,
  output logic merge,
  output logic erase,
  output logic prog,
  output logic busy,
  output logic done
);
  seq_state_t st;
  logic [CW-1:0] cnt;
  logic erase_last, prog_last;

  assign erase_last = (cnt == CW'(ERASE_CYC - 1));
  assign prog_last  = (cnt == CW'(PROG_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start) begin
          st  <= is_pw ? SQ_MERGE : SQ_PROG;
          cnt <= '0;
        end
        SQ_MERGE: begin
          st  <= SQ_ERASE;
          cnt <= '0;
        end
        SQ_ERASE: if (erase_last) begin
          st  <= SQ_PROG;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        SQ_PROG: if (prog_last) st <= SQ_IDLE;
                 else cnt <= cnt + 1'b1;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign merge = (st == SQ_MERGE);
  assign erase = (st == SQ_ERASE) && erase_last;
  assign prog  = (st == SQ_PROG) && prog_last;
  assign done  = prog;
  assign busy  = (st != SQ_IDLE);
endmodule

// File: rtl/spiflash_pgwr.sv
module spiflash_pgwr
  import spiflash_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int ERASE_CYC = 64,
  parameter int PROG_CYC  = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              spi_sclk,
  input  logic                              spi_cs_n,
  input  logic                              spi_mosi,
  output logic                              spi_miso,
  input  logic [$clog2(NUM_PAGES)+OFF_W-1:0] rd_addr,
  output logic [7:0]                        rd_data
);
  localparam int PG_W = $clog2(NUM_PAGES);

  logic       sel, sel_fall, cs_rise, on_boundary, byte_vld;
  logic [2:0] bit_cnt;
  logic [7:0] byte_data;

  sfp_spi_front u_front (
    .clk, .rst_n, .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sel, .sel_fall, .cs_rise, .on_boundary, .bit_cnt, .byte_vld, .byte_data
  );

  // frame decode
  logic [2:0]       byte_idx;
  logic [7:0]       opcode;
  logic [PG_W-1:0]  frm_page, run_page;
  logic [OFF_W-1:0] off;
  logic             frame_ok, got_data, rs_mode, wel, run_pw;
  logic             busy, done, merge, erase, prog, start;
  logic             buf_clr, buf_wr;

  assign buf_clr = byte_vld && byte_idx == 3'd0 && !busy;
  assign buf_wr  = byte_vld && byte_idx == 3'd4 && frame_ok;
  assign start   = cs_rise && frame_ok && got_data && on_boundary && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx <= '0;
      opcode   <= '0;
      frm_page <= '0;
      run_page <= '0;
      off      <= '0;
      frame_ok <= 1'b0;
      got_data <= 1'b0;
      rs_mode  <= 1'b0;
      wel      <= 1'b0;
      run_pw   <= 1'b0;
    end else begin
      if (sel_fall) begin
        byte_idx <= '0;
        frame_ok <= 1'b0;
        got_data <= 1'b0;
      end else if (byte_vld) begin
        if (byte_idx != 3'd4) byte_idx <= byte_idx + 3'd1;
        unique case (byte_idx)
          3'd0: begin
            opcode   <= byte_data;
            rs_mode  <= (byte_data == OP_RDSR);
            frame_ok <= !busy && wel && (byte_data == OP_PW || byte_data == OP_PP);
            if (byte_data == OP_WREN && !busy) wel <= 1'b1;
          end
          3'd2: frm_page <= byte_data[PG_W-1:0];
          3'd3: off <= byte_data[OFF_W-1:0];
          3'd4: if (frame_ok) begin
            off      <= off + 1'b1;
            got_data <= 1'b1;
          end
          default: ;
        endcase
      end
      if (!sel) rs_mode <= 1'b0;
      if (start) begin
        run_page <= frm_page;
        run_pw   <= (opcode == OP_PW);
      end
      if (done) wel <= 1'b0;
    end
  end

  logic [7:0] status;
  assign status   = {6'b0, wel, busy};
  assign spi_miso = rs_mode & status[3'd7 - bit_cnt];

  sfp_wr_seq #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk, .rst_n, .start, .is_pw(run_pw_next), .merge, .erase, .prog, .busy, .done
  );

  logic run_pw_next;
  assign run_pw_next = (opcode == OP_PW);

  logic [PAGE_BYTES-1:0][7:0] pbuf, cur_page;

  sfp_page_buf u_buf (
    .clk, .rst_n, .clr(buf_clr), .wr_en(buf_wr), .wr_off(off), .wr_data(byte_data),
    .merge, .old_page(cur_page), .data(pbuf)
  );

  sfp_array #(.NUM_PAGES(NUM_PAGES)) u_arr (
    .clk, .rst_n, .page_sel(busy ? run_page : frm_page), .erase, .prog, .pbuf,
    .cur_page, .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/sfp_checker.sv
module sfp_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic miso,
  input logic wip,
  input logic wel
);
  AST_BUSY_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> wel); // R4
  AST_BUSY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> cs_n); // R7
  AST_LATCH_HELD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> wel); // R3
  AST_LATCH_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel); // R3
  AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !miso); // R2
endmodule

bind spiflash_pgwr sfp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .miso(spi_miso), .wip(busy), .wel(wel)
);

// File: tb/spiflash_pgwr_test.sv
`timescale 1ns/1ps
module spiflash_pgwr_test;
  localparam int NP = 2;
  localparam int EC = 600;
  localparam int PC = 250;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [8:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_run = 0, n_fail = 0;
  logic [7:0] em [NP*256];

  always #4 clk = ~clk;

  spiflash_pgwr #(.NUM_PAGES(NP), .ERASE_CYC(EC), .PROG_CYC(PC)) uut (
    .clk, .rst_n, .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .rd_addr, .rd_data
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input int seed, input int k);
    return 8'(k * 7 + seed * 13 + (k >> 3));
  endfunction

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (4) @(negedge clk); cs_n = 1'b1; repeat (8) @(negedge clk);
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_lo(); xfer(8'h05, d); xfer(8'h00, s); cs_hi();
  endtask

  task automatic wren();
    logic [7:0] d;
    cs_lo(); xfer(8'h06, d); cs_hi();
  endtask

  task automatic send_wr(input logic [7:0] op, input logic [23:0] a, input int n, input int seed);
    logic [7:0] d;
    cs_lo();
    xfer(op, d); xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int k = 0; k < n; k++) xfer(dat(seed, k), d);
    cs_hi();
  endtask

  // bench model: gather the frame into a page image, then apply it
  task automatic model(input bit pw, input logic [23:0] a, input int n, input int seed);
    logic [7:0] b [256];
    bit g [256];
    int pg = int'(a[8]);
    for (int i = 0; i < 256; i++) begin b[i] = 8'hFF; g[i] = 1'b0; end
    for (int k = 0; k < n; k++) begin
      b[(int'(a[7:0]) + k) % 256] = dat(seed, k);
      g[(int'(a[7:0]) + k) % 256] = 1'b1;
    end
    for (int i = 0; i < 256; i++)
      if (g[i]) em[pg*256+i] = pw ? b[i] : (em[pg*256+i] & b[i]);
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    int tries = 0;
    do begin rdsr(s); tries++; end while (s[0] && tries < 50);
    check(s[0] == 1'b0, tag, s, 0);
  endtask

  task automatic check_array(input string tag);
    int bad = 0, first = -1;
    logic [7:0] fa = 0, fe = 0;
    for (int i = 0; i < NP*256; i++) begin
      rd_addr = 9'(i);
      #1;
      if (rd_data !== em[i]) begin
        if (first < 0) begin first = i; fa = rd_data; fe = em[i]; end
        bad++;
      end
    end
    @(negedge clk);
    if (bad != 0) $display("  first mismatch at 0x%0h", first);
    check(bad == 0, tag, fa, fe);
  endtask

  task automatic check_stat(input logic [7:0] exp, input string tag);
    logic [7:0] s;
    rdsr(s);
    check(s === exp, tag, s, exp);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, s1, s2;
    for (int i = 0; i < NP*256; i++) em[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R12: reset state
    check_stat(8'h00, "R1 status after reset");
    check_array("R1 R12 store erased after reset");

    // R4: program without enable is ignored
    send_wr(8'h02, 24'h000000, 16, 9);
    check_stat(8'h00, "R4 status after unenabled program");
    check_array("R4 store unchanged");

    // R2 R3: enable then status repeats within one frame
    wren();
    cs_lo(); xfer(8'h05, d); xfer(8'h00, s1); xfer(8'h00, s2); cs_hi();
    check(s1 === 8'h02, "R3 latch set by enable", s1, 8'h02);
    check(s2 === 8'h02, "R2 status repeats", s2, 8'h02);

    // R9 R10 R5: full page program on page 0
    send_wr(8'h02, 24'h000000, 256, 1);
    model(1'b0, 24'h000000, 256, 1);
    check_stat(8'h03, "R10 busy during program");
    wait_idle("R10 busy ends");
    check_stat(8'h00, "R3 latch cleared at end");
    check_array("R9 R5 full page program");

    // R9: program ANDs into old contents
    wren();
    send_wr(8'h02, 24'h000010, 40, 2);
    model(1'b0, 24'h000010, 40, 2);
    wait_idle("R9 cycle ends");
    check_array("R9 program only clears bits");

    // R8: full page write on page 1
    wren();
    send_wr(8'h0A, 24'h000100, 256, 3);
    model(1'b1, 24'h000100, 256, 3);
    check_stat(8'h03, "R10 busy during page write");
    wait_idle("R8 cycle ends");
    check_array("R8 full page write");

    // R6 R8: partial write wrapping past 255, merge keeps the rest
    wren();
    send_wr(8'h0A, 24'h0000FA, 10, 4);
    model(1'b1, 24'h0000FA, 10, 4);
    wait_idle("R6 cycle ends");
    check_array("R6 R8 wrap and merge");

    // R6: more than a page in one frame, later bytes win
    wren();
    send_wr(8'h0A, 24'h000105, 300, 5);
    model(1'b1, 24'h000105, 300, 5);
    wait_idle("R6 long frame ends");
    check_array("R6 overwrite within frame");

    // R7: select rises mid-byte after data
    wren();
    cs_lo();
    xfer(8'h0A, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h20, d); xfer(8'h11, d);
    for (int i = 0; i < 4; i++) begin
      mosi = 1'b0; repeat (4) @(negedge clk); sclk = 1'b1; repeat (4) @(negedge clk); sclk = 1'b0;
    end
    cs_hi();
    check_stat(8'h02, "R7 mid-byte frame discarded, latch kept");
    // R7: frame with no data byte
    send_wr(8'h0A, 24'h000030, 0, 6);
    check_stat(8'h02, "R7 frame without data discarded");
    check_array("R7 store unchanged");

    // R5: high address bits ignored, page from bit 8
    send_wr(8'h02, 24'hA50140, 20, 10);
    model(1'b0, 24'hA50140, 20, 10);
    wait_idle("R5 cycle ends");
    check_array("R5 page select ignores upper bits");

    // R11: commands during a cycle are ignored
    wren();
    send_wr(8'h0A, 24'h000000, 4, 7);
    model(1'b1, 24'h000000, 4, 7);
    wren();
    send_wr(8'h02, 24'h000100, 2, 8);
    check_stat(8'h03, "R11 still busy after ignored frames");
    wait_idle("R11 cycle ends");
    check_stat(8'h00, "R11 enable during busy ignored");
    check_array("R11 program during busy ignored");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule